// File: doc/BRIEF.md
# Crossbar Associative-Memory Training Sequencer

This block is the digital controller behind the training loop of a pair of crossbar weight arrays that together act as an auto-associative memory. When software pulses `start`, the sequencer first asks the analog side to put both arrays into a mid-range weight state. It then repeats a recall-and-correct loop. Each pass draws one prototype from a stored set of `N_PAT` patterns and sends it out for recall. It then takes back a ternary error vector with one element per bit.

If every error element is zero, the pattern counts as passed. The streak of consecutive passes grows, and that pattern is barred from later draws in the same streak. If any element is nonzero, the streak is cleared, every pattern becomes eligible again, and the sequencer issues update commands for one array only. The array is chosen by the parity of the iteration number. Updates go column by column and skip columns whose error is zero. Training ends with `done` when the streak reaches `N_PAT`. It ends with `timeout` when the iteration budget runs out first.

Each of the four data exchanges is a valid/ready pair: initialise, recall request, recall result and update command. An outgoing valid, once raised, holds with its payload stable until the cycle in which the matching ready is high. The transfer happens on that clock edge. Only one exchange is open at any time. The sequencer never drops a valid on its own, so the analog side may stall any exchange for as long as it needs.

Top module: `xbar_train_seq`

## Requirements
- R1: After `start`, the sequencer raises `init_valid` and holds it until `init_ready` is seen. No recall request is raised before that initialise transfer completes.
- R2: A pattern drawn for recall is never one that has already passed in the current streak. After an error, all patterns may be drawn again. Pattern k is bits `[k*N_BITS +: N_BITS]` of `pat_table`, where bit value 1 means +1 and 0 means −1.
- R3: `rc_pat` carries the drawn pattern in the `pat_table` encoding. While `rc_valid` is high and `rc_ready` is low, `rc_valid` and `rc_pat` stay unchanged.
- R4: A result with `res_nz` all zero raises `streak` by one, one cycle after the result transfer. No update command is issued for that iteration.
- R5: A result with any `res_nz` bit set clears `streak` to 0, one cycle after the result transfer. Element i of the error is 0 when `res_nz[i]`=0, +1 when `res_nz[i]`=1 and `res_neg[i]`=0, and −1 when both are 1.
- R6: When `streak` reaches `N_PAT`, `done` rises and stays high with no further requests until the next `start`.
- R7: Iterations are numbered from 1 after each `start`. Updates after an odd-numbered iteration have `upd_array`=0 (first array). Updates after an even-numbered iteration have `upd_array`=1 (second array).
- R8: Update commands are issued only for columns with a nonzero error, in ascending column order. `upd_col_gnd` is one-hot, with bit j set for column j: that column is grounded and all the other columns sit at half drive.
- R9: `upd_rows` bit i is 1 for positive drive and 0 for negative drive. For the first array it equals the pattern when the column error is +1, and the inverted pattern when it is −1. The second array gets the inverse of both cases.
- R10: While `upd_valid` is high and `upd_ready` is low, `upd_valid`, `upd_array`, `upd_col_gnd` and `upd_rows` stay unchanged.
- R11: If an iteration numbered `iter_limit` or higher does not complete training, the sequencer stops with `timeout`=1 and `done`=0. It issues no update for that iteration and no further requests.
- R12: `res_ready` is high only while a recall result is awaited, after a recall request has transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (accepted when idle, done or timed out) |
| iter_limit | input | ITER_W | Iteration budget for the run |
| pat_table | input | N_PAT*N_BITS | Prototype patterns, 1 = +1, 0 = −1 |
| init_valid | output | 1 | Initialise-arrays command valid |
| init_ready | input | 1 | Initialise command accepted |
| rc_valid | output | 1 | Recall request valid |
| rc_ready | input | 1 | Recall request accepted |
| rc_pat | output | N_BITS | Pattern to recall |
| res_valid | input | 1 | Recall result valid |
| res_ready | output | 1 | Sequencer awaits a result |
| res_nz | input | N_BITS | Error element nonzero flags |
| res_neg | input | N_BITS | Error element sign (1 = −1) |
| upd_valid | output | 1 | Column update command valid |
| upd_ready | input | 1 | Update command accepted |
| upd_array | output | 1 | 0 = first array, 1 = second array |
| upd_col_gnd | output | N_BITS | One-hot grounded column |
| upd_rows | output | N_BITS | Row drive polarity, 1 = positive |
| streak | output | CNT_W | Consecutive passed patterns |
| done | output | 1 | Training completed |
| timeout | output | 1 | Iteration budget exhausted |

## Verification
The assertions check several properties on every cycle. At most one exchange is open at a time, and every stalled valid holds its payload. An update column is always one-hot. A drawn pattern is never one already in the streak. The streak never exceeds `N_PAT`, `done` implies a full streak, and the pattern generator never locks up at zero. Only the directed scenarios can show the rest. These are the ordering of initialise before recall, the odd/even array choice, the exact row polarity for each error sign and array, the skipping of zero-error columns, and the clearing of the streak after an error. They also cover the stop on a full streak and the stop at the iteration budget with its updates suppressed.

// File: rtl/xts_pkg.sv
package xts_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_PICK, S_REQ, S_WAIT, S_EVAL, S_UPD, S_DONE, S_TOUT
  } xts_state_e;
endpackage

// File: rtl/xts_lfsr.sv
module xts_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= (s_q >> 1) ^ (s_q[0] ? TAPS : '0);
  end

  assign state = s_q;

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_q != '0);
endmodule

// File: rtl/xts_pick.sv
module xts_pick #(
  parameter int unsigned N_PAT = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [IDX_W-1:0] draw,
  input  logic [N_PAT-1:0] excl,
  output logic             accept
);
  localparam int unsigned SPAN = 2 ** IDX_W;
  logic [SPAN-1:0] excl_ext;
  logic            in_range;

  assign excl_ext = SPAN'(excl);
  assign in_range = ({1'b0, draw} < (IDX_W + 1)'(N_PAT));
  assign accept   = in_range && !excl_ext[draw];
endmodule

// File: rtl/xts_rowdrv.sv
module xts_rowdrv #(
  parameter int unsigned N_BITS = 8,
  parameter int unsigned COL_W  = 3
) (
  input  logic [N_BITS-1:0] pat,
  input  logic              neg,
  input  logic              arr,
  input  logic [COL_W-1:0]  col,
  output logic [N_BITS-1:0] rows,
  output logic [N_BITS-1:0] col_gnd
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    assign rows[i]    = pat[i] ^ neg ^ arr;
    assign col_gnd[i] = (col == COL_W'(i));
  end
endmodule

// File: rtl/xbar_train_seq.sv
module xbar_train_seq
  import xts_pkg::*;
#(
  parameter int unsigned N_BITS = 8,
  parameter int unsigned N_PAT  = 4,
  parameter int unsigned ITER_W = 12,
  parameter int unsigned LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
  localparam int unsigned IDX_W = (N_PAT > 1) ? $clog2(N_PAT) : 1,
  localparam int unsigned COL_W = (N_BITS > 1) ? $clog2(N_BITS) : 1,
  localparam int unsigned CNT_W = $clog2(N_PAT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ITER_W-1:0]       iter_limit,
  input  logic [N_PAT*N_BITS-1:0] pat_table,
  output logic                    init_valid,
  input  logic                    init_ready,
  output logic                    rc_valid,
  input  logic                    rc_ready,
  output logic [N_BITS-1:0]       rc_pat,
  input  logic                    res_valid,
  output logic                    res_ready,
  input  logic [N_BITS-1:0]       res_nz,
  input  logic [N_BITS-1:0]       res_neg,
  output logic                    upd_valid,
  input  logic                    upd_ready,
  output logic                    upd_array,
  output logic [N_BITS-1:0]       upd_col_gnd,
  output logic [N_BITS-1:0]       upd_rows,
  output logic [CNT_W-1:0]        streak,
  output logic                    done,
  output logic                    timeout
);
  xts_state_e        state_q;
  logic [ITER_W-1:0] iter_q;
  logic [CNT_W-1:0]  streak_q;
  logic [N_PAT-1:0]  mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic [N_BITS-1:0] pat_q, nz_q, neg_q;
  logic [COL_W-1:0]  col_q;
  logic              arr_q;

  logic [LFSR_W-1:0] lfsr_s;
  logic [IDX_W-1:0]  draw;
  logic              accept;
  logic [CNT_W-1:0]  streak_inc;
  logic              at_limit, last_col;

  xts_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_s)
  );

  assign draw = lfsr_s[IDX_W-1:0];

  xts_pick #(.N_PAT(N_PAT), .IDX_W(IDX_W)) u_pick (
    .draw(draw), .excl(mask_q), .accept(accept)
  );

  xts_rowdrv #(.N_BITS(N_BITS), .COL_W(COL_W)) u_drv (
    .pat(pat_q), .neg(neg_q[col_q]), .arr(arr_q), .col(col_q),
    .rows(upd_rows), .col_gnd(upd_col_gnd)
  );

  assign streak_inc = streak_q + CNT_W'(1);
  assign at_limit   = (iter_q >= iter_limit);
  assign last_col   = (col_q == COL_W'(N_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      iter_q   <= '0;
      streak_q <= '0;
      mask_q   <= '0;
      idx_q    <= '0;
      pat_q    <= '0;
      nz_q     <= '0;
      neg_q    <= '0;
      col_q    <= '0;
      arr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE, S_TOUT: begin
          if (start) begin
            state_q  <= S_INIT;
            iter_q   <= '0;
            streak_q <= '0;
            mask_q   <= '0;
          end
        end
        S_INIT: if (init_ready) state_q <= S_PICK;
        S_PICK: begin
          if (accept) begin
            idx_q   <= draw;
            pat_q   <= pat_table[draw*N_BITS +: N_BITS];
            iter_q  <= iter_q + ITER_W'(1);
            state_q <= S_REQ;
          end
        end
        S_REQ: if (rc_ready) state_q <= S_WAIT;
        S_WAIT: begin
          if (res_valid) begin
            nz_q    <= res_nz;
            neg_q   <= res_neg;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (nz_q == '0) begin
            streak_q      <= streak_inc;
            mask_q[idx_q] <= 1'b1;
            if (streak_inc == CNT_W'(N_PAT)) state_q <= S_DONE;
            else if (at_limit)               state_q <= S_TOUT;
            else                             state_q <= S_PICK;
          end else begin
            streak_q <= '0;
            mask_q   <= '0;
            col_q    <= '0;
            arr_q    <= ~iter_q[0];
            state_q  <= at_limit ? S_TOUT : S_UPD;
          end
        end
        S_UPD: begin
          if (!nz_q[col_q] || upd_ready) begin
            if (last_col) state_q <= S_PICK;
            else          col_q   <= col_q + COL_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign init_valid = (state_q == S_INIT);
  assign rc_valid   = (state_q == S_REQ);
  assign res_ready  = (state_q == S_WAIT);
  assign upd_valid  = (state_q == S_UPD) && nz_q[col_q];
  assign upd_array  = arr_q;
  assign rc_pat     = pat_q;
  assign streak     = streak_q;
  assign done       = (state_q == S_DONE);
  assign timeout    = (state_q == S_TOUT);

  p_one_exchange_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_valid, rc_valid, res_ready, upd_valid}));

  p_rc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid && !rc_ready |=> rc_valid && $stable(rc_pat));

  p_upd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid && $stable(upd_rows)
      && $stable(upd_col_gnd) && $stable(upd_array));

  p_col_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $countones(upd_col_gnd) == 1);

  p_no_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_valid) |-> !mask_q[idx_q]);

  p_streak_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q <= CNT_W'(N_PAT));

  p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> streak_q == CNT_W'(N_PAT));

  p_not_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
endmodule

// File: tb/xbar_train_seq_bench.sv
module xbar_train_seq_bench;
  localparam int NB = 8;
  localparam int NP = 4;
  localparam int IW = 12;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [IW-1:0] iter_limit;
  logic [NP*NB-1:0] pat_table;
  logic init_valid, init_ready, rc_valid, rc_ready, res_valid, res_ready;
  logic [NB-1:0] rc_pat, res_nz, res_neg, upd_col_gnd, upd_rows;
  logic upd_valid, upd_ready, upd_array, done, timeout;
  logic [2:0] streak;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xbar_train_seq #(.N_BITS(NB), .N_PAT(NP), .ITER_W(IW)) u_xbar_train_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_limit(iter_limit),
    .pat_table(pat_table), .init_valid(init_valid), .init_ready(init_ready),
    .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_pat(rc_pat),
    .res_valid(res_valid), .res_ready(res_ready), .res_nz(res_nz),
    .res_neg(res_neg), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_array(upd_array), .upd_col_gnd(upd_col_gnd), .upd_rows(upd_rows),
    .streak(streak), .done(done), .timeout(timeout)
  );

  always @(posedge clk) if (upd_valid && upd_ready) upd_cnt <= upd_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int find_idx(input logic [NB-1:0] p);
    for (int k = 0; k < NP; k++) if (pat_table[k*NB +: NB] == p) return k;
    return -1;
  endfunction

  task automatic pulse_start(input int lim);
    iter_limit = IW'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic accept_init();
    while (!init_valid) @(negedge clk);
    init_ready = 1'b1;
    @(negedge clk);
    init_ready = 1'b0;
  endtask

  task automatic accept_rc(output int idx, output logic [NB-1:0] p);
    while (!rc_valid) @(negedge clk);
    p = rc_pat;
    idx = find_idx(rc_pat);
    chk(idx >= 0, "R3 rc_pat is a stored pattern", rc_pat, 0);
    rc_ready = 1'b1;
    @(negedge clk);
    rc_ready = 1'b0;
  endtask

  task automatic give_res(input logic [NB-1:0] nz, input logic [NB-1:0] ng);
    res_valid = 1'b1; res_nz = nz; res_neg = ng;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0; res_nz = '0; res_neg = '0;
  endtask

  task automatic expect_upd(input int col, input bit arr, input logic [NB-1:0] rows, input bit hold);
    while (!upd_valid) @(negedge clk);
    chk(upd_col_gnd == NB'(1 << col), "R8 grounded column", upd_col_gnd, 1 << col);
    chk(upd_array == arr, "R7 array by parity", upd_array, arr);
    chk(upd_rows == rows, "R9 row polarity", upd_rows, rows);
    if (hold) begin
      repeat (2) @(negedge clk);
      chk(upd_valid && upd_rows == rows && upd_col_gnd == NB'(1 << col),
          "R10 stalled update held", upd_rows, rows);
    end
    upd_ready = 1'b1;
    @(negedge clk);
    upd_ready = 1'b0;
  endtask

  task automatic pass_iter(inout logic [NP-1:0] seen, input int exp_streak);
    int idx; logic [NB-1:0] p; int u0;
    accept_rc(idx, p);
    chk(!seen[idx], "R2 drawn pattern not in streak", idx, -1);
    seen[idx] = 1'b1;
    u0 = upd_cnt;
    give_res('0, '0);
    @(negedge clk);
    chk(streak == 3'(exp_streak), "R4 streak grows on pass", streak, exp_streak);
    chk(upd_cnt == u0, "R4 no update on pass", upd_cnt, u0);
  endtask

  task automatic t_reset();
    chk(!init_valid && !rc_valid && !upd_valid && !res_ready, "R12 idle after reset",
        {init_valid, rc_valid, upd_valid, res_ready}, 0);
    chk(!done && !timeout && streak == 0, "R6 no done after reset", {done, timeout}, 0);
  endtask

  task automatic t_init(input int lim);
    pulse_start(lim);
    chk(init_valid && !rc_valid, "R1 init raised first", {init_valid, rc_valid}, 2);
    repeat (3) @(negedge clk);
    chk(init_valid && !rc_valid && !res_ready, "R1 init held under stall",
        {init_valid, rc_valid}, 2);
    accept_init();
  endtask

  task automatic t_all_pass();
    logic [NP-1:0] seen = '0;
    t_init(50);
    for (int i = 1; i <= NP; i++) pass_iter(seen, i);
    chk(done && !timeout, "R6 done at full streak", {done, timeout}, 2);
    repeat (6) @(negedge clk);
    chk(done && !rc_valid && !init_valid, "R6 done holds, no requests", {done, rc_valid}, 2);
  endtask

  task automatic t_error_run();
    logic [NP-1:0] seen = '0;
    int idx; logic [NB-1:0] p; int u0;
    t_init(50);
    pass_iter(seen, 1);
    accept_rc(idx, p);
    chk(!seen[idx], "R2 drawn pattern not in streak", idx, -1);
    chk(res_ready == 1'b1, "R12 result awaited after request", res_ready, 1);
    u0 = upd_cnt;
    give_res(8'b1000_0101, 8'b0000_0100);
    @(negedge clk);
    chk(streak == 0, "R5 streak cleared on error", streak, 0);
    expect_upd(0, 1'b1, ~p, 1'b1);
    expect_upd(2, 1'b1, p, 1'b0);
    expect_upd(7, 1'b1, ~p, 1'b0);
    accept_rc(idx, p);
    chk(upd_cnt == u0 + 3, "R8 only nonzero columns updated", upd_cnt - u0, 3);
    give_res(8'b0000_0010, 8'b0000_0000);
    expect_upd(1, 1'b0, p, 1'b0);
    seen = '0;
    for (int i = 1; i <= NP; i++) pass_iter(seen, i);
    chk(done, "R6 done after recovering", done, 1);
  endtask

  task automatic t_timeout();
    int idx; logic [NB-1:0] p; int u0;
    t_init(3);
    accept_rc(idx, p);
    give_res(8'b0001_0000, 8'b0001_0000);
    expect_upd(4, 1'b0, ~p, 1'b0);
    accept_rc(idx, p);
    give_res(8'b0001_0000, 8'b0001_0000);
    expect_upd(4, 1'b1, p, 1'b0);
    accept_rc(idx, p);
    u0 = upd_cnt;
    give_res(8'b0001_0000, 8'b0001_0000);
    @(negedge clk);
    chk(timeout && !done, "R11 timeout at limit", {timeout, done}, 2);
    repeat (5) @(negedge clk);
    chk(upd_cnt == u0 && !upd_valid && !rc_valid, "R11 no update or request after limit",
        upd_cnt - u0, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; iter_limit = '0;
    pat_table = {8'h96, 8'hF0, 8'h3C, 8'hA5};
    init_ready = 1'b0; rc_ready = 1'b0; res_valid = 1'b0;
    res_nz = '0; res_neg = '0; upd_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_all_pass();
    t_error_run();
    t_timeout();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end
endmodule